// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block turns a system clock into the timing strobes a CAN protocol engine needs for each nominal bit. A programmable prescaler cuts the clock into time quanta. A segment sequencer then walks each bit through a one-quantum sync segment, a first phase segment and a second phase segment. It flags the end of the sync quantum, the sample point and every quantum boundary.

The received bus level passes through a two-flop synchronizer. A dominant-going edge re-aligns the bit counter. While the protocol layer reports the bus idle, the edge restarts the bit outright. During a frame, a late edge stretches phase segment 1 and an early edge trims phase segment 2. The correction never exceeds the jump width, and only one correction is made per bit. The bus level seen at each sample point is held on an output.

Timing comes from one packed 15-bit word, and each field in it holds its length minus one. The word is copied only while the block is held in init.

Top module: `can_bit_timing`

## Requirements
- R1: `cfg_i` packs phase segment 2 minus one in [14:12], phase segment 1 minus one in [11:8], jump width minus one in [7:6] and prescaler minus one in [5:0]. One quantum is BRP clocks. `tq_tick_o` is high on the last clock of every quantum. Example: 0x0700 gives BRP=1 and a 10-quantum bit, and 0x34C1 gives BRP=2 and a 20-clock bit.
- R2: `bit_start_o` pulses on the last clock of the sync quantum. In steady state it repeats every (1+TSeg1+TSeg2)·BRP clocks.
- R3: `sample_o` pulses for one clock on the last clock of phase segment 1, which is TSeg1·BRP clocks after `bit_start_o`.
- R4: While `init_i` is high, all strobes stay low. The first `tq_tick_o` and `bit_start_o` come on the BRP-th clock after `init_i` falls, counting that clock as the first.
- R5: A change of `cfg_i` while `init_i` is low has no effect on timing.
- R6: When `bus_idle_i` is high, `rx_i` falling (1 = recessive) restarts the bit. `bit_start_o` then pulses on the (BRP+2)-th clock edge after the edge that first samples the low level.
- R7: When the bus is busy, a falling edge in phase segment 1 at quantum index q lengthens that segment by min(q+1, SJW) quanta.
- R8: When the bus is busy, a falling edge in phase segment 2 with r quanta left restarts the bit if r ≤ SJW. Otherwise it shortens phase segment 2 by SJW quanta.
- R9: Only the first busy-bus edge of a bit makes a correction. Later edges in the same bit are ignored.
- R10: `rx_bit_o` shows the synchronized bus level captured at the most recent sample point, and resets to 1.
- R11: Rising edges of `rx_i` cause no synchronization.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| init_i | input | 1 | Hold in init and capture `cfg_i` |
| cfg_i | input | 15 | Packed timing word |
| bus_idle_i | input | 1 | Bus idle: edges hard-synchronize |
| rx_i | input | 1 | Raw receive level, 1 = recessive |
| tq_tick_o | output | 1 | Last clock of each quantum |
| bit_start_o | output | 1 | Last clock of the sync quantum |
| sample_o | output | 1 | Sample point strobe |
| rx_bit_o | output | 1 | Level captured at the sample point |

## Verification
An edge correction can land in the same cycle as a quantum boundary or a sample point. The correction must then change that boundary rather than come one quantum late. The bench places edges at exact quantum indices inside each phase segment, including the first quantum of phase segment 1, a capped late edge and both early-edge outcomes. It judges the shifted sample point and the next bit start against arithmetic on the segment lengths. A hard restart is placed mid-bit away from the nominal boundaries, and a second edge in the same bit is checked for no further shift.

// File: rtl/can_btg_pkg.sv
package can_btg_pkg;
  localparam int TS2_W = 3;
  localparam int TS1_W = 4;
  localparam int SJW_W = 2;
  localparam int BRP_W = 6;
  localparam int CFG_W = TS2_W + TS1_W + SJW_W + BRP_W;

  typedef struct packed {
    logic [TS2_W-1:0] ts2_m1;
    logic [TS1_W-1:0] ts1_m1;
    logic [SJW_W-1:0] sjw_m1;
    logic [BRP_W-1:0] brp_m1;
  } timing_t;

  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_TS1  = 2'd1,
    SEG_TS2  = 2'd2
  } seg_e;
endpackage

// File: rtl/can_btg_rx_sync.sv
module can_btg_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  output logic rx_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[g] <= 1'b1;
        else         sync_q[g] <= rx_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[g] <= 1'b1;
        else         sync_q[g] <= sync_q[g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= sync_q[STAGES-1];

  assign rx_o   = sync_q[STAGES-1];
  assign fall_o = prev_q & ~sync_q[STAGES-1];

  p_no_double_fall_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/can_btg_prescaler.sv
module can_btg_prescaler #(
  parameter int BRP_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [BRP_W-1:0] brp_m1_i,
  output logic             tick_o
);
  logic [BRP_W-1:0] cnt_q;

  assign tick_o = !clr_i && (cnt_q == brp_m1_i);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;

  p_cnt_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |-> cnt_q <= brp_m1_i);
  p_clr_restarts_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
endmodule

// File: rtl/can_btg_seg.sv
module can_btg_seg
  import can_btg_pkg::*;
#(
  parameter int T1_W = TS1_W,
  parameter int T2_W = TS2_W,
  parameter int SJ_W = SJW_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            init_i,
  input  logic            tick_i,
  input  logic            fall_i,
  input  logic            idle_i,
  input  logic [T1_W-1:0] ts1_m1_i,
  input  logic [T2_W-1:0] ts2_m1_i,
  input  logic [SJ_W-1:0] sjw_m1_i,
  output logic            restart_o,
  output logic            bit_start_o,
  output logic            sample_o
);
  localparam int QC_W = T1_W + 2;

  seg_e            state_q;
  logic [QC_W-1:0] qc_q, ext_q, sh_q;
  logic            done_q;

  logic [QC_W-1:0] ts1_len, ts2_len, sjw_len, err, ext_n, sh_n;
  logic            hard, resync, early_restart, ts1_end, ts2_end;

  assign ts1_len = QC_W'(ts1_m1_i) + 1'b1;
  assign ts2_len = QC_W'(ts2_m1_i) + 1'b1;
  assign sjw_len = QC_W'(sjw_m1_i) + 1'b1;

  assign hard   = fall_i && idle_i;
  assign resync = fall_i && !idle_i && !done_q && (state_q != SEG_SYNC);

  always_comb begin
    ext_n         = ext_q;
    sh_n          = sh_q;
    early_restart = 1'b0;
    err           = '0;
    if (resync && state_q == SEG_TS1) begin
      err   = qc_q + 1'b1;                 // late by q+1 quanta
      ext_n = (err < sjw_len) ? err : sjw_len;
    end else if (resync && state_q == SEG_TS2) begin
      err = ts2_len - qc_q;                // early by remaining quanta
      if (err <= sjw_len) early_restart = 1'b1;
      else                sh_n = sjw_len;
    end
  end

  assign restart_o   = hard || early_restart;
  assign ts1_end     = (qc_q == ts1_len + ext_n - 1'b1);
  assign ts2_end     = (qc_q == ts2_len - sh_n - 1'b1);
  assign sample_o    = tick_i && (state_q == SEG_TS1) && ts1_end;
  assign bit_start_o = tick_i && (state_q == SEG_SYNC);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state_q <= SEG_SYNC;
      qc_q    <= '0;
      ext_q   <= '0;
      sh_q    <= '0;
      done_q  <= 1'b0;
    end else if (init_i || restart_o) begin
      state_q <= SEG_SYNC;
      qc_q    <= '0;
      ext_q   <= '0;
      sh_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      if (resync) begin
        done_q <= 1'b1;
        ext_q  <= ext_n;
        sh_q   <= sh_n;
      end
      if (tick_i) begin
        unique case (state_q)
          SEG_SYNC: begin
            state_q <= SEG_TS1;
            qc_q    <= '0;
            ext_q   <= '0;
            sh_q    <= '0;
            done_q  <= 1'b0;
          end
          SEG_TS1: begin
            if (ts1_end) begin
              state_q <= SEG_TS2;
              qc_q    <= '0;
            end else qc_q <= qc_q + 1'b1;
          end
          SEG_TS2: begin
            if (ts2_end) begin
              state_q <= SEG_SYNC;
              qc_q    <= '0;
            end else qc_q <= qc_q + 1'b1;
          end
          default: state_q <= SEG_SYNC;
        endcase
      end
    end

  p_sample_to_ts2_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_o && !init_i) |=> (state_q == SEG_TS2 && qc_q == '0));
  p_ext_cap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_q <= sjw_len);
  p_one_resync_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !bit_start_o && !restart_o && !init_i) |=> ($stable(ext_q) && $stable(sh_q)));
  p_hard_sync_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hard && !init_i) |=> (state_q == SEG_SYNC && qc_q == '0));
endmodule

// File: rtl/can_bit_timing.sv
module can_bit_timing
  import can_btg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             bus_idle_i,
  input  logic             rx_i,
  output logic             tq_tick_o,
  output logic             bit_start_o,
  output logic             sample_o,
  output logic             rx_bit_o
);
  timing_t cfg_q;
  logic    rx_sync, fall, restart, tick;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     cfg_q <= '0;
    else if (init_i) cfg_q <= timing_t'(cfg_i);

  can_btg_rx_sync #(.STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rx_i   (rx_i),
    .rx_o   (rx_sync),
    .fall_o (fall)
  );

  can_btg_prescaler #(.BRP_W(BRP_W)) u_presc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (init_i || restart),
    .brp_m1_i (cfg_q.brp_m1),
    .tick_o   (tick)
  );

  can_btg_seg #(.T1_W(TS1_W), .T2_W(TS2_W), .SJ_W(SJW_W)) u_seg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .init_i      (init_i),
    .tick_i      (tick),
    .fall_i      (fall),
    .idle_i      (bus_idle_i),
    .ts1_m1_i    (cfg_q.ts1_m1),
    .ts2_m1_i    (cfg_q.ts2_m1),
    .sjw_m1_i    (cfg_q.sjw_m1),
    .restart_o   (restart),
    .bit_start_o (bit_start_o),
    .sample_o    (sample_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)       rx_bit_o <= 1'b1;
    else if (sample_o) rx_bit_o <= rx_sync;

  assign tq_tick_o = tick;

  p_rx_capture_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |=> rx_bit_o == $past(rx_sync));
  p_init_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |-> !(tq_tick_o || bit_start_o || sample_o));
endmodule

// File: tb/sim_can_bit_timing.sv
module sim_can_bit_timing;
  localparam time CLK_P = 10ns;
  localparam int  LOG_N = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init = 1'b1;
  logic [14:0] cfg = '0;
  logic        idle = 1'b1;
  logic        rx = 1'b1;
  logic        tq_tick, bit_start, sample, rx_bit;

  int checks = 0;
  int fails = 0;

  bit bs_log [LOG_N];
  bit sm_log [LOG_N];
  bit tk_log [LOG_N];
  bit rb_log [LOG_N];

  int   ev_c [4];
  logic ev_v [4];
  int   ev_n = 0;
  int   alt_c = -1;
  logic [14:0] alt_cfg = '0;
  logic rx_init = 1'b1;

  always #(CLK_P/2) clk = ~clk;

  can_bit_timing u0 (
    .clk_i(clk), .rst_ni(rst_n), .init_i(init), .cfg_i(cfg),
    .bus_idle_i(idle), .rx_i(rx), .tq_tick_o(tq_tick),
    .bit_start_o(bit_start), .sample_o(sample), .rx_bit_o(rx_bit)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [14:0] mk_cfg(input int t1, input int t2, input int sjw, input int brp);
    return {3'(t2-1), 4'(t1-1), 2'(sjw-1), 6'(brp-1)};
  endfunction

  function automatic int first_at(input int kind, input int from);
    for (int c = from; c < LOG_N; c++) begin
      if (kind == 0 && bs_log[c]) return c;
      if (kind == 1 && sm_log[c]) return c;
    end
    return -1;
  endfunction

  task automatic run_cfg(input logic [14:0] c_w, input logic idle_v, input int n);
    int quiet;
    @(negedge clk);
    init = 1'b1; cfg = c_w; idle = idle_v; rx = rx_init;
    quiet = 1;
    repeat (4) begin
      @(posedge clk); #1;
      if (tq_tick || bit_start || sample) quiet = 0;
    end
    chk(quiet == 1, "R4 strobes low in init", quiet, 1);
    for (int c = 0; c < LOG_N; c++) begin
      bs_log[c] = 0; sm_log[c] = 0; tk_log[c] = 0; rb_log[c] = 0;
    end
    @(negedge clk);
    init = 1'b0;
    for (int c = 0; c < n; c++) begin
      #1;
      bs_log[c] = bit_start; sm_log[c] = sample;
      tk_log[c] = tq_tick;   rb_log[c] = rx_bit;
      for (int e = 0; e < ev_n; e++) if (ev_c[e] == c) rx = ev_v[e];
      if (c == alt_c) cfg = alt_cfg;
      @(negedge clk);
    end
    ev_n = 0; alt_c = -1; rx_init = 1'b1;
  endtask

  task automatic add_ev(input int c, input logic v);
    ev_c[ev_n] = c; ev_v[ev_n] = v; ev_n++;
  endtask

  initial begin
    #(CLK_P * 200000);
    chk(0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int bt, mis_t, mis_b, mis_s, n, bs0;
    #(CLK_P * 3);
    #1;
    chk(!tq_tick && !bit_start && !sample, "R4 reset strobes", int'(tq_tick | bit_start | sample), 0);
    chk(rx_bit == 1'b1, "R10 reset level", int'(rx_bit), 1);
    @(negedge clk);
    rst_n = 1'b1;

    // R1, R2, R3: sweep of segment and prescaler lengths
    for (int brp = 1; brp <= 3; brp++)
      for (int t1 = 1; t1 <= 6; t1++)
        for (int t2 = 1; t2 <= 4; t2++) begin
          bt = 1 + t1 + t2;
          n  = 2 * bt * brp + brp + 2;
          run_cfg(mk_cfg(t1, t2, 1, brp), 1'b0, n);
          mis_t = 0; mis_b = 0; mis_s = 0;
          for (int c = 0; c < n; c++) begin
            bs0 = c - (brp - 1);
            if (tk_log[c] != ((c + 1) % brp == 0)) mis_t++;
            if (bs_log[c] != (bs0 >= 0 && bs0 % (bt * brp) == 0)) mis_b++;
            if (sm_log[c] != (bs0 - t1 * brp >= 0 && (bs0 - t1 * brp) % (bt * brp) == 0)) mis_s++;
          end
          chk(mis_t == 0, "R1 quantum tick pattern", mis_t, 0);
          chk(mis_b == 0, "R2 bit start pattern", mis_b, 0);
          chk(mis_s == 0, "R3 sample pattern", mis_s, 0);
        end

    // R1 packed examples
    run_cfg(15'h0700, 1'b0, 25);
    chk(first_at(0, 1) == 10, "R1 0x0700 bit period", first_at(0, 1), 10);
    chk(first_at(1, 0) == 8, "R1 0x0700 sample", first_at(1, 0), 8);
    run_cfg(15'h34C1, 1'b0, 45);
    chk(first_at(0, 2) == 21, "R1 0x34C1 bit period", first_at(0, 2), 21);
    chk(first_at(1, 0) == 11, "R1 0x34C1 sample", first_at(1, 0), 11);

    // R6 hard sync on idle bus, BRP=2, 20-clock bit
    add_ev(25, 1'b0);
    run_cfg(15'h34C1, 1'b1, 52);
    chk(first_at(0, 22) == 29, "R6 hard sync restart", first_at(0, 22), 29);
    chk(first_at(1, 30) == 39, "R6 sample after restart", first_at(1, 30), 39);
    chk(first_at(0, 30) == 49, "R6 next bit start", first_at(0, 30), 49);

    // TS1=5 TS2=4 SJW=2 BRP=1; second bit starts at 10
    add_ev(9, 1'b0);
    run_cfg(mk_cfg(5, 4, 2, 1), 1'b0, 25);
    chk(first_at(1, 11) == 16, "R7 edge in first TS1 quantum", first_at(1, 11), 16);
    chk(first_at(0, 11) == 21, "R7 bit start after lengthening", first_at(0, 11), 21);

    add_ev(11, 1'b0);
    run_cfg(mk_cfg(5, 4, 2, 1), 1'b0, 25);
    chk(first_at(1, 11) == 17, "R7 lengthening capped at SJW", first_at(1, 11), 17);
    chk(first_at(0, 11) == 22, "R7 bit start after capped", first_at(0, 11), 22);

    add_ev(9, 1'b0); add_ev(10, 1'b1); add_ev(11, 1'b0);
    run_cfg(mk_cfg(5, 4, 2, 1), 1'b0, 25);
    chk(first_at(1, 11) == 16, "R9 second edge ignored", first_at(1, 11), 16);

    add_ev(16, 1'b0);
    run_cfg(mk_cfg(5, 4, 2, 1), 1'b0, 25);
    chk(first_at(0, 11) == 19, "R8 early edge within SJW restarts", first_at(0, 11), 19);

    add_ev(14, 1'b0);
    run_cfg(mk_cfg(5, 4, 2, 1), 1'b0, 25);
    chk(first_at(1, 11) == 15, "R8 sample unaffected", first_at(1, 11), 15);
    chk(first_at(0, 11) == 18, "R8 TS2 shortened by SJW", first_at(0, 11), 18);

    // R11, R10: start low, rising edge mid TS1
    rx_init = 1'b0;
    add_ev(11, 1'b1);
    run_cfg(mk_cfg(5, 4, 2, 1), 1'b0, 25);
    chk(first_at(1, 11) == 15, "R11 rising edge no shift", first_at(1, 11), 15);
    chk(first_at(0, 11) == 20, "R11 bit start unshifted", first_at(0, 11), 20);
    chk(rb_log[6] == 1'b0, "R10 captured dominant", int'(rb_log[6]), 0);
    chk(rb_log[16] == 1'b1, "R10 captured recessive", int'(rb_log[16]), 1);

    // R5 config change outside init ignored
    alt_c = 3; alt_cfg = mk_cfg(2, 1, 1, 3);
    run_cfg(mk_cfg(5, 4, 2, 1), 1'b0, 32);
    chk(first_at(0, 11) == 20, "R5 config ignored when running", first_at(0, 11), 20);
    chk(first_at(1, 16) == 25, "R5 sample unchanged", first_at(1, 16), 25);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule